// File: doc/BRIEF.md
# Masked Three-Operand Bitwise Logic Unit

This block evaluates an arbitrary three-input boolean function across a wide vector. Each cycle it can accept three operand vectors and an 8-bit function code. The function code is a truth table: each result bit is the entry selected by the three operand bits at the same position. Every one of the 256 possible functions of three inputs can therefore be chosen at run time without changing the hardware. Examples are select, majority, three-way XOR and NAND.

After the logic stage, an optional per-element write mask is applied. The element width is 32 or 64 bits. A lane whose mask bit is clear either keeps the old destination value supplied on a port (merge) or is forced to zero (zero). The element width has an effect only when masking is on. The mask bits and the old destination come from the surrounding pipeline. The result is registered and is flagged with `out_valid` one cycle after the inputs are captured.

Top module: `vtl_unit`

## Requirements
- R1: Result bit j equals `tt_imm[{op_a[j], op_b[j], op_c[j]}]`, with op_a the most significant index bit and op_c the least. Each bit depends only on the operand bits at position j.
- R2: With `tt_imm` = 8'hCA and masking off, the result is the bitwise select `(op_a & op_b) | (~op_a & op_c)`.
- R3: With `mask_mode` 2'b00 or 2'b11, masking is off. Every bit takes the function value, and `wmask`, `old_dst` and `elem64` have no effect on the result.
- R4: With `mask_mode` 2'b01 (merge) and `elem64` = 0, lane i is bits 32i+31..32i and is governed by `wmask[i]`. A lane whose mask bit is 0 takes the `old_dst` bits. A lane whose mask bit is 1 takes the function value.
- R5: With `mask_mode` 2'b10 (zero), a lane whose mask bit is 0 is all zeros. A lane whose mask bit is 1 takes the function value.
- R6: With `elem64` = 1, lane i is bits 64i+63..64i and is governed by `wmask[i]` for i = 0..7. `wmask[15:8]` has no effect on the result.
- R7: Inputs are captured on a rising edge where `in_valid` is 1. The result and `out_valid` = 1 appear after that same edge. `out_valid` is 0 after any edge where `in_valid` was 0.
- R8: While `in_valid` is 0, `result` keeps its last value, whatever the other inputs do.
- R9: While `rst` is high, `out_valid` and `result` are 0 after each rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for all operand inputs |
| op_a | input | 512 | Operand supplying the most significant index bit |
| op_b | input | 512 | Operand supplying the middle index bit |
| op_c | input | 512 | Operand supplying the least significant index bit |
| tt_imm | input | 8 | Truth table of the three-input function |
| old_dst | input | 512 | Previous destination value, used under merge masking |
| wmask | input | 16 | Per-element write mask |
| mask_mode | input | 2 | 00/11 off, 01 merge, 10 zero |
| elem64 | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| out_valid | output | 1 | Result valid, one cycle after capture |
| result | output | 512 | Registered masked result |

## Verification
The function evaluation and the lane masking act in the same cycle on the same bits. A wrong lane boundary, a swapped index order or a wrong mask source therefore shows up as a corrupted bit pattern. The bench sweeps all 256 truth tables with operands that cover all eight bit combinations. It then repeats many masked operations under both modes and both element sizes, with varying masks and distinct old-destination data. Each full 512-bit result is compared against a bit-by-bit model, in which lane membership is computed arithmetically from the bit index and the element size.

// File: rtl/vtl_pkg.sv
package vtl_pkg;

    localparam int unsigned MIN_ELEM_W = 32;
    localparam int unsigned TT_W       = 8;

    typedef enum logic [1:0] {
        MM_OFF     = 2'b00,
        MM_MERGE   = 2'b01,
        MM_ZERO    = 2'b10,
        MM_OFF_ALT = 2'b11
    } mask_mode_e;

    typedef struct packed {
        logic take_fn;
        logic take_old;
    } lane_sel_t;

    function automatic lane_sel_t lane_choice(input mask_mode_e mode, input logic en);
        lane_sel_t s;
        s.take_fn  = (mode == MM_OFF) || (mode == MM_OFF_ALT) || en;
        s.take_old = (mode == MM_MERGE) && !en;
        return s;
    endfunction

endpackage

// File: rtl/vtl_bitfunc.sv
module vtl_bitfunc #(
    parameter int unsigned VEC_W = 512
) (
    input  logic [VEC_W-1:0]         a,
    input  logic [VEC_W-1:0]         b,
    input  logic [VEC_W-1:0]         c,
    input  logic [vtl_pkg::TT_W-1:0] tt,
    output logic [VEC_W-1:0]         y
);
    for (genvar j = 0; j < VEC_W; j++) begin : g_bit
        assign y[j] = tt[{a[j], b[j], c[j]}];
    end
endmodule

// File: rtl/vtl_lane_mask.sv
module vtl_lane_mask
    import vtl_pkg::*;
#(
    parameter int unsigned VEC_W = 512,
    localparam int unsigned NLANE = VEC_W / MIN_ELEM_W
) (
    input  logic [NLANE-1:0] wmask,
    input  logic             elem64,
    input  mask_mode_e       mode,
    output logic [VEC_W-1:0] take_fn,
    output logic [VEC_W-1:0] take_old
);
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic      en;
        lane_sel_t sel;
        assign en  = elem64 ? wmask[i/2] : wmask[i];
        assign sel = lane_choice(mode, en);
        assign take_fn[i*MIN_ELEM_W +: MIN_ELEM_W]  = {MIN_ELEM_W{sel.take_fn}};
        assign take_old[i*MIN_ELEM_W +: MIN_ELEM_W] = {MIN_ELEM_W{sel.take_old}};
    end
endmodule

// File: rtl/vtl_unit.sv
module vtl_unit
    import vtl_pkg::*;
#(
    parameter int unsigned VEC_W = 512,
    localparam int unsigned NLANE = VEC_W / MIN_ELEM_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   op_a,
    input  logic [VEC_W-1:0]   op_b,
    input  logic [VEC_W-1:0]   op_c,
    input  logic [TT_W-1:0]    tt_imm,
    input  logic [VEC_W-1:0]   old_dst,
    input  logic [NLANE-1:0]   wmask,
    input  logic [1:0]         mask_mode,
    input  logic               elem64,
    output logic               out_valid,
    output logic [VEC_W-1:0]   result
);
    logic [VEC_W-1:0] fn_val;
    logic [VEC_W-1:0] take_fn;
    logic [VEC_W-1:0] take_old;
    logic [VEC_W-1:0] next_res;
    mask_mode_e       mode;

    assign mode = mask_mode_e'(mask_mode);

    vtl_bitfunc #(.VEC_W(VEC_W)) u_func (
        .a  (op_a),
        .b  (op_b),
        .c  (op_c),
        .tt (tt_imm),
        .y  (fn_val)
    );

    vtl_lane_mask #(.VEC_W(VEC_W)) u_mask (
        .wmask    (wmask),
        .elem64   (elem64),
        .mode     (mode),
        .take_fn  (take_fn),
        .take_old (take_old)
    );

    assign next_res = (fn_val & take_fn) | (old_dst & take_old);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_res;
            end
        end
    end
endmodule

module vtl_unit_chk #(
    parameter int unsigned VEC_W = 512
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             a0,
    input logic             b0,
    input logic             c0,
    input logic [7:0]       tt_imm,
    input logic [31:0]      old_lo,
    input logic             wm0,
    input logic [1:0]       mask_mode,
    input logic             out_valid,
    input logic [VEC_W-1:0] result
);
    // R7
    capture_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R1
    bit0_table_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (mask_mode == 2'b00)) |=> (result[0] == $past(tt_imm[{a0, b0, c0}])));

    // R5
    zero_lane0_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (mask_mode == 2'b10) && !wm0) |=> (result[31:0] == 32'h0));

    // R4
    merge_lane0_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (mask_mode == 2'b01) && !wm0) |=> (result[31:0] == $past(old_lo)));
endmodule

bind vtl_unit vtl_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a0        (op_a[0]),
    .b0        (op_b[0]),
    .c0        (op_c[0]),
    .tt_imm    (tt_imm),
    .old_lo    (old_dst[31:0]),
    .wm0       (wmask[0]),
    .mask_mode (mask_mode),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/vtl_unit_test.sv
module vtl_unit_test;
    localparam int W  = 512;
    localparam int NL = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  op_a = '0, op_b = '0, op_c = '0, old_dst = '0;
    logic [7:0]    tt_imm = '0;
    logic [NL-1:0] wmask = '0;
    logic [1:0]    mask_mode = 2'b00;
    logic          elem64 = 1'b0;
    logic          out_valid;
    logic [W-1:0]  result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vtl_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .tt_imm(tt_imm),
        .old_dst(old_dst), .wmask(wmask), .mask_mode(mask_mode),
        .elem64(elem64), .out_valid(out_valid), .result(result)
    );

    function automatic logic [W-1:0] model(
        input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
        input logic [7:0] tt, input logic [W-1:0] od, input logic [NL-1:0] m,
        input logic [1:0] md, input logic e64);
        logic [W-1:0] r;
        for (int j = 0; j < W; j++) begin
            int idx;
            int lane;
            logic fv;
            idx  = 4 * int'(a[j]) + 2 * int'(b[j]) + int'(c[j]);
            fv   = tt[idx];
            lane = e64 ? j / 64 : j / 32;
            if (md == 2'b00 || md == 2'b11 || m[lane]) r[j] = fv;
            else if (md == 2'b01)                     r[j] = od[j];
            else                                      r[j] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rnd_vec();
        logic [W-1:0] v;
        for (int k = 0; k < W / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_vec(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: result got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] c, input logic [7:0] tt, input logic [W-1:0] od,
                          input logic [NL-1:0] m, input logic [1:0] md, input logic e64,
                          input logic [W-1:0] exp);
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; tt_imm = tt; old_dst = od;
        wmask = m; mask_mode = md; elem64 = e64; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({req, " out_valid"}, out_valid, 1'b1);
        check_vec(req, result, exp);
    endtask

    logic [W-1:0] pa, pb, pc;

    initial begin
        logic [W-1:0] a, b, c, od, held;
        // operands covering all eight bit combinations, repeating every 8 bits
        for (int j = 0; j < W; j++) begin
            pa[j] = (j % 8) >= 4;
            pb[j] = ((j % 8) / 2) % 2 == 1;
            pc[j] = (j % 2) == 1;
        end

        // R9: reset state
        repeat (3) @(negedge clk);
        check_bit("R9 out_valid", out_valid, 1'b0);
        check_vec("R9", result, '0);
        rst = 1'b0;

        // R1, R3: every truth table, masking off, element size toggled
        for (int t = 0; t < 256; t++) begin
            logic [W-1:0] e;
            e = '0;
            for (int j = 0; j < W; j++) e[j] = t[j % 8];
            run_op("R1", pa, pb, pc, 8'(t), rnd_vec(), 16'($urandom), 2'b00, 1'(t % 2), e);
        end

        // R2: select function
        for (int k = 0; k < 4; k++) begin
            a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
            run_op("R2", a, b, c, 8'hCA, rnd_vec(), 16'h0, 2'b00, 1'b0, (a & b) | (~a & c));
        end

        // R3: alternate off encoding ignores mask, old data and element size
        a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
        run_op("R3", a, b, c, 8'h96, rnd_vec(), 16'h0, 2'b11, 1'b1, a ^ b ^ c);
        run_op("R3", a, b, c, 8'hE8, rnd_vec(), 16'h5A5A, 2'b00, 1'b0,
               (a & b) | (a & c) | (b & c));

        // R4, R5, R6: masked sweeps
        for (int md = 1; md <= 2; md++) begin
            for (int e = 0; e < 2; e++) begin
                for (int k = 0; k < 10; k++) begin
                    logic [NL-1:0] m;
                    logic [7:0] tt;
                    string tag;
                    m  = (k == 0) ? 16'h0 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h00FF :
                         (k == 3) ? 16'hFF00 : 16'($urandom);
                    tt = 8'($urandom);
                    a = rnd_vec(); b = rnd_vec(); c = rnd_vec(); od = rnd_vec();
                    tag = e ? "R6" : (md == 1 ? "R4" : "R5");
                    run_op(tag, a, b, c, tt, od, m, 2'(md), 1'(e),
                           model(a, b, c, tt, od, m, 2'(md), 1'(e)));
                end
            end
        end

        // R6: upper mask half ignored for 64-bit elements
        a = rnd_vec(); b = rnd_vec(); c = rnd_vec(); od = rnd_vec();
        run_op("R6", a, b, c, 8'hF0, od, 16'hAB00 | 16'h0035, 2'b10, 1'b1,
               model(a, b, c, 8'hF0, od, 16'h0035, 2'b10, 1'b1));

        // R7, R8: idle cycles with changing inputs keep the result and drop valid
        held = result;
        for (int k = 0; k < 4; k++) begin
            op_a = rnd_vec(); op_b = rnd_vec(); op_c = rnd_vec(); old_dst = rnd_vec();
            tt_imm = 8'($urandom); wmask = 16'($urandom); mask_mode = 2'($urandom);
            @(negedge clk);
            check_bit("R7 idle out_valid", out_valid, 1'b0);
            check_vec("R8", result, held);
        end

        // R7: back-to-back captures
        @(negedge clk);
        op_a = pa; op_b = pb; op_c = pc; tt_imm = 8'h01; mask_mode = 2'b00; in_valid = 1'b1;
        @(negedge clk);
        check_bit("R7 b2b first valid", out_valid, 1'b1);
        check_vec("R7", result, model(pa, pb, pc, 8'h01, '0, '0, 2'b00, 1'b0));
        tt_imm = 8'h80;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R7 b2b second valid", out_valid, 1'b1);
        check_vec("R7", result, model(pa, pb, pc, 8'h80, '0, '0, 2'b00, 1'b0));

        // R9: reset again clears
        rst = 1'b1;
        @(negedge clk);
        check_bit("R9 out_valid", out_valid, 1'b0);
        check_vec("R9", result, '0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule